// File: doc/BRIEF.md
# SPI controller register frontend

This block is the software-facing side of a four-channel SPI master. It decodes aligned 32-bit word accesses into ten register slots, owns a transmit and a receive word queue, keeps the live queue flags together with two sticky event bits, drives a single level interrupt and four active-low chip selects, and turns particular register writes into start requests for a separate burst exchange engine.

The engine sees the transmit queue through a head word, an availability flag and a pop strobe. It hands back received words with a valid strobe and reports the end of a burst with a done pulse. Every bus access is accepted in the cycle it is presented, and its acknowledge and read data follow one clock later. Clearing the enable bit through a control write performs a soft reset of the whole block. A start that arrives while the engine reports busy is held until the engine is idle again.

Top module: `spi_reg_frontend`

## Requirements
- R1: The register slot is the byte address shifted right by two: 0 control, 1 status, 2 interrupt mask, 3 transmit push, 4 receive pop, 5 config, 6 dma, 7 period, 8 test, 9 message. An unaligned access (address bits 1:0 not zero) or a slot of 10 or more reads as zero and changes nothing. Every access is acknowledged one cycle after it is presented.
- R2: A read of slot 4 returns zero when control bit 0 (enable) is clear. It returns 32'hDEADBEEF when enabled and the receive queue is empty. Otherwise it returns and removes the oldest received word.
- R3: Reads of slots 3 and 9 return zero. Writes to slots 4 and 9 change nothing.
- R4: A write to slot 3 is dropped when enable is clear or the 64-word transmit queue is full. Otherwise the word is appended. The engine sees the oldest word and an availability flag, and its pop strobe removes that word.
- R5: Status bits are: 0 transmit empty, 1 transmit data request (fixed at 1), 2 transmit full, 3 receive not empty, 4 receive data request (fixed at 0), 5 receive full, 6 receive overrun, 7 burst done. Bit 6 sets when the engine delivers a word into a full receive queue, and the word is lost. Bit 7 sets on the engine done pulse. Writing a one clears bit 6 or bit 7, but a set in the same cycle wins. All other status bits ignore writes.
- R6: A control write with bit 0 clear, and also the hardware reset, zeroes every stored register, empties both queues, clears pending starts and drives all chip selects high. Status then reads 32'h00000003.
- R7: The interrupt output is high exactly when some status bit and the same interrupt mask bit are both set.
- R8: Control bits 13:12 select a channel, and control bits 7:4 mark which channels are masters. A control write that keeps enable set and names a master channel drives that channel's chip select low and the other three high. A write that names a non-master channel leaves the chip selects unchanged.
- R9: A start is requested when the channel selected by the present control value is a master and one of three things happens: a transmit push is accepted while control bit 3 (auto start) is set; a control write raises bit 3 while the transmit queue is not empty; or a control write raises bit 2 (kick) while the written bit 3 is clear.
- R10: A requested start stays pending while the engine reports busy. The start output is high while a start is pending and the engine is idle, and the pending start clears at the next clock edge.
- R11: Slots 0, 2, 5, 6, 7 and 8 read back the last value written, and the control value only changes through R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Access present this cycle |
| bus_write_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_ack_o | output | 1 | Acknowledge, one cycle after the access |
| bus_rdata_o | output | 32 | Read data, valid with the acknowledge |
| irq_o | output | 1 | Level interrupt |
| cs_n_o | output | 4 | Active-low chip selects |
| start_o | output | 1 | Start request to the burst engine |
| eng_busy_i | input | 1 | Engine is busy with a burst |
| eng_tx_pop_i | input | 1 | Engine takes the oldest transmit word |
| eng_tx_word_o | output | 32 | Oldest transmit word |
| eng_tx_avail_o | output | 1 | Transmit queue not empty |
| eng_rx_valid_i | input | 1 | Engine delivers a received word |
| eng_rx_word_i | input | 32 | Received word |
| eng_done_i | input | 1 | Engine finished a burst |

## Verification
Each bus access leaves its acknowledge and read data one clock after it is presented. Queue contents, status flags, the interrupt level and the chip selects reflect that access after the same single edge. A start request is registered on the edge of its cause and appears on `start_o` straight after that edge, unless the busy input holds it back. The bench drives every input just after a falling edge, advances a behavioural queue model to what the next rising edge should produce, and compares all outputs at the following falling edge. This puts every comparison exactly one edge after its stimulus. Because `start_o` also follows the busy input without a clock, its release is sampled shortly after busy drops and before the next rising edge.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CHAN_N = 4;
  localparam int CHAN_W = 2;

  // register slots (word index)
  localparam int IDX_CTRL  = 0;
  localparam int IDX_STAT  = 1;
  localparam int IDX_MASK  = 2;
  localparam int IDX_TXD   = 3;
  localparam int IDX_RXD   = 4;
  localparam int IDX_CFG   = 5;
  localparam int IDX_DMA   = 6;
  localparam int IDX_PER   = 7;
  localparam int IDX_TEST  = 8;
  localparam int REG_COUNT = 10;  // slot 9 is the message slot

  // control fields
  localparam int C_EN      = 0;
  localparam int C_KICK    = 2;
  localparam int C_AUTO    = 3;
  localparam int C_MODE_LO = 4;
  localparam int C_SEL_LO  = 12;

  // status bits
  localparam int S_TE  = 0;
  localparam int S_TDR = 1;
  localparam int S_TF  = 2;
  localparam int S_RR  = 3;
  localparam int S_RDR = 4;
  localparam int S_RF  = 5;
  localparam int S_RO  = 6;
  localparam int S_TC  = 7;

  localparam logic [31:0] EMPTY_READ = 32'hDEAD_BEEF;

  function automatic logic [CHAN_W-1:0] sel_of(logic [31:0] c);
    return c[C_SEL_LO +: CHAN_W];
  endfunction

  function automatic logic is_master(logic [31:0] c);
    logic [CHAN_N-1:0] mode;
    mode = c[C_MODE_LO +: CHAN_N];
    return mode[sel_of(c)];
  endfunction

  function automatic logic [CHAN_N-1:0] cs_pattern(logic [31:0] c);
    logic [CHAN_N-1:0] p;
    p = '1;
    p[sel_of(c)] = 1'b0;
    return p;
  endfunction

  function automatic logic [7:0] pack_status(logic te, logic tf, logic rr,
                                             logic rf, logic ro, logic tc);
    logic [7:0] s;
    s        = 8'h00;
    s[S_TE]  = te;
    s[S_TDR] = 1'b1;
    s[S_TF]  = tf;
    s[S_RR]  = rr;
    s[S_RDR] = 1'b0;
    s[S_RF]  = rf;
    s[S_RO]  = ro;
    s[S_TC]  = tc;
    return s;
  endfunction
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int DEPTH = 64,  // power of two
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = PTR_W + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] level;
  logic             do_push, do_pop;

  assign empty_o = (level == '0);
  assign full_o  = (level == LVL_W'(DEPTH));
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push && !flush_i) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
    end
  end

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  assert_push_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i && !flush_i) |=> full_o);
endmodule

// File: rtl/spi_start_ctl.sv
module spi_start_ctl
  import spi_fe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear_i,
  input  logic        tx_push_ok_i,
  input  logic        ctrl_wr_i,
  input  logic [31:0] ctrl_old_i,
  input  logic [31:0] ctrl_new_i,
  input  logic        tx_nonempty_i,
  input  logic        busy_i,
  output logic        start_o
);
  timeunit 1ns;
  timeprecision 100ps;

  logic rise_kick, rise_auto;
  logic trig_push, trig_auto, trig_kick, trig_any;
  logic pend_q;

  assign rise_kick = ctrl_new_i[C_KICK] & ~ctrl_old_i[C_KICK];
  assign rise_auto = ctrl_new_i[C_AUTO] & ~ctrl_old_i[C_AUTO];

  assign trig_push = tx_push_ok_i & ctrl_old_i[C_AUTO] & is_master(ctrl_old_i);
  assign trig_auto = ctrl_wr_i & is_master(ctrl_new_i) & rise_auto & tx_nonempty_i;
  assign trig_kick = ctrl_wr_i & is_master(ctrl_new_i) & rise_kick & ~ctrl_new_i[C_AUTO];
  assign trig_any  = trig_push | trig_auto | trig_kick;

  assign start_o = pend_q & ~busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (clear_i) pend_q <= 1'b0;
    else              pend_q <= (pend_q & ~start_o) | trig_any;
  end

  assert_hold_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && busy_i && !clear_i) |=> pend_q);

  assert_kick_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_kick && !clear_i) |=> pend_q);
endmodule

// File: rtl/spi_reg_frontend.sv
module spi_reg_frontend
  import spi_fe_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int FIFO_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic              bus_ack_o,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  output logic [3:0]        cs_n_o,
  output logic              start_o,
  input  logic              eng_busy_i,
  input  logic              eng_tx_pop_i,
  output logic [31:0]       eng_tx_word_o,
  output logic              eng_tx_avail_o,
  input  logic              eng_rx_valid_i,
  input  logic [31:0]       eng_rx_word_i,
  input  logic              eng_done_i
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int IDX_W = ADDR_W - 2;

  // decoded access events
  logic [IDX_W-1:0] idx;
  logic aligned, in_map, wr_ok, rd_ok;
  logic ctrl_wr_hit, soft_rst, ctrl_wr_live;
  logic tx_wr_hit, tx_push_ok, rx_rd_hit, rx_pop_ok;
  logic stat_wr, rx_push_ok, rx_ovf;

  // state
  logic [31:0] ctrl_q, cfg_q, mask_q, dma_q, per_q, test_q;
  logic        ro_q, tc_q, ack_q;
  logic [3:0]  cs_q;
  logic [31:0] rdata_q, rd_val, stat_word, rx_head;
  logic        tx_empty, tx_full, rx_empty, rx_full;

  assign idx     = bus_addr_i[ADDR_W-1:2];
  assign aligned = (bus_addr_i[1:0] == 2'b00);
  assign in_map  = aligned && (idx < IDX_W'(REG_COUNT));
  assign wr_ok   = bus_valid_i & bus_write_i & in_map;
  assign rd_ok   = bus_valid_i & ~bus_write_i & in_map;

  assign ctrl_wr_hit  = wr_ok & (idx == IDX_W'(IDX_CTRL));
  assign soft_rst     = ctrl_wr_hit & ~bus_wdata_i[C_EN];
  assign ctrl_wr_live = ctrl_wr_hit & bus_wdata_i[C_EN];
  assign tx_wr_hit    = wr_ok & (idx == IDX_W'(IDX_TXD));
  assign tx_push_ok   = tx_wr_hit & ctrl_q[C_EN] & ~tx_full;
  assign rx_rd_hit    = rd_ok & (idx == IDX_W'(IDX_RXD));
  assign rx_pop_ok    = rx_rd_hit & ctrl_q[C_EN] & ~rx_empty;
  assign stat_wr      = wr_ok & (idx == IDX_W'(IDX_STAT));
  assign rx_push_ok   = eng_rx_valid_i & ~rx_full;
  assign rx_ovf       = eng_rx_valid_i & rx_full;

  spi_word_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush_i(soft_rst),
    .push_i(tx_push_ok), .data_i(bus_wdata_i),
    .pop_i(eng_tx_pop_i), .head_o(eng_tx_word_o),
    .empty_o(tx_empty), .full_o(tx_full)
  );

  spi_word_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush_i(soft_rst),
    .push_i(rx_push_ok), .data_i(eng_rx_word_i),
    .pop_i(rx_pop_ok), .head_o(rx_head),
    .empty_o(rx_empty), .full_o(rx_full)
  );

  spi_start_ctl u_start (
    .clk(clk), .rst_n(rst_n), .clear_i(soft_rst),
    .tx_push_ok_i(tx_push_ok), .ctrl_wr_i(ctrl_wr_live),
    .ctrl_old_i(ctrl_q), .ctrl_new_i(bus_wdata_i),
    .tx_nonempty_i(~tx_empty), .busy_i(eng_busy_i),
    .start_o(start_o)
  );

  assign stat_word      = {24'h0, pack_status(tx_empty, tx_full, ~rx_empty,
                                              rx_full, ro_q, tc_q)};
  assign irq_o          = |(stat_word & mask_q);
  assign cs_n_o         = cs_q;
  assign eng_tx_avail_o = ~tx_empty;
  assign bus_ack_o      = ack_q;
  assign bus_rdata_o    = rdata_q;

  always_comb begin
    rd_val = '0;
    if (in_map) begin
      case (idx)
        IDX_W'(IDX_CTRL): rd_val = ctrl_q;
        IDX_W'(IDX_STAT): rd_val = stat_word;
        IDX_W'(IDX_MASK): rd_val = mask_q;
        IDX_W'(IDX_RXD):  rd_val = !ctrl_q[C_EN] ? 32'h0 :
                                   (rx_empty ? EMPTY_READ : rx_head);
        IDX_W'(IDX_CFG):  rd_val = cfg_q;
        IDX_W'(IDX_DMA):  rd_val = dma_q;
        IDX_W'(IDX_PER):  rd_val = per_q;
        IDX_W'(IDX_TEST): rd_val = test_q;
        default:          rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0; rdata_q <= '0;
      ctrl_q <= '0; cfg_q <= '0; mask_q <= '0; dma_q <= '0; per_q <= '0; test_q <= '0;
      ro_q <= 1'b0; tc_q <= 1'b0; cs_q <= '1;
    end else begin
      ack_q   <= bus_valid_i;
      rdata_q <= (bus_valid_i && !bus_write_i) ? rd_val : '0;
      if (soft_rst) begin
        ctrl_q <= '0; cfg_q <= '0; mask_q <= '0; dma_q <= '0; per_q <= '0; test_q <= '0;
        ro_q <= 1'b0; tc_q <= 1'b0; cs_q <= '1;
      end else begin
        if (ctrl_wr_live) begin
          ctrl_q <= bus_wdata_i;
          if (is_master(bus_wdata_i)) cs_q <= cs_pattern(bus_wdata_i);
        end
        if (wr_ok && idx == IDX_W'(IDX_MASK)) mask_q <= bus_wdata_i;
        if (wr_ok && idx == IDX_W'(IDX_CFG))  cfg_q  <= bus_wdata_i;
        if (wr_ok && idx == IDX_W'(IDX_DMA))  dma_q  <= bus_wdata_i;
        if (wr_ok && idx == IDX_W'(IDX_PER))  per_q  <= bus_wdata_i;
        if (wr_ok && idx == IDX_W'(IDX_TEST)) test_q <= bus_wdata_i;
        ro_q <= (ro_q & ~(stat_wr & bus_wdata_i[S_RO])) | rx_ovf;
        tc_q <= (tc_q & ~(stat_wr & bus_wdata_i[S_TC])) | eng_done_i;
      end
    end
  end

  assert_out_of_map_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && !bus_write_i && !in_map) |=> (bus_ack_o && bus_rdata_o == 32'h0));

  assert_empty_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_hit && ctrl_q[C_EN] && rx_empty) |=> (bus_ack_o && bus_rdata_o == EMPTY_READ));

  assert_disabled_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_hit && !ctrl_q[C_EN]) |=> (bus_rdata_o == 32'h0));

  assert_tx_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_hit && tx_full && !eng_tx_pop_i) |=> tx_full);

  assert_w1c_tc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && bus_wdata_i[S_TC] && !eng_done_i) |=> !stat_word[S_TC]);

  assert_soft_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (stat_word == 32'h3 && cs_n_o == 4'hF && !start_o));

  assert_cs_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n_o));
endmodule

// File: tb/spi_reg_frontend_tb.sv
module spi_reg_frontend_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW = 12;
  localparam int DEPTH = 64;
  localparam logic [31:0] EN = 32'h1, KICK = 32'h4, AUTO = 32'h8, MODE0 = 32'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic b_valid = 0, b_write = 0;
  logic [AW-1:0] b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic e_busy = 0, e_pop = 0, e_rxv = 0, e_done = 0;
  logic [31:0] e_rxw = '0;

  logic ack, irq, start, avail;
  logic [31:0] rdata, word;
  logic [3:0] cs;

  spi_reg_frontend #(.ADDR_W(AW), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .bus_valid_i(b_valid), .bus_write_i(b_write), .bus_addr_i(b_addr),
    .bus_wdata_i(b_wdata), .bus_ack_o(ack), .bus_rdata_o(rdata),
    .irq_o(irq), .cs_n_o(cs), .start_o(start), .eng_busy_i(e_busy),
    .eng_tx_pop_i(e_pop), .eng_tx_word_o(word), .eng_tx_avail_o(avail),
    .eng_rx_valid_i(e_rxv), .eng_rx_word_i(e_rxw), .eng_done_i(e_done)
  );

  int vectors = 0, errors = 0;
  bit finished = 0;

  // behavioural model state
  logic [31:0] m_ctrl, m_cfg, m_mask, m_dma, m_per, m_test, m_rdata;
  logic [31:0] txq[$], rxq[$];
  bit m_ro, m_tc, m_pend, m_ack;
  logic [3:0] m_cs;
  string m_rtag = "R1";

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] mstat();
    logic [31:0] s = 32'h2;               // bit1 always one
    if (txq.size() == 0)     s |= 32'h01;
    if (txq.size() == DEPTH) s |= 32'h04;
    if (rxq.size() != 0)     s |= 32'h08;
    if (rxq.size() == DEPTH) s |= 32'h20;
    if (m_ro)                s |= 32'h40;
    if (m_tc)                s |= 32'h80;
    return s;
  endfunction

  function automatic bit mmaster(logic [31:0] c);
    int sel = int'((c >> 12) & 3);
    return bit'((c >> (4 + sel)) & 1);
  endfunction

  task automatic model_reset();
    m_ctrl = 0; m_cfg = 0; m_mask = 0; m_dma = 0; m_per = 0; m_test = 0;
    txq.delete(); rxq.delete();
    m_ro = 0; m_tc = 0; m_pend = 0; m_cs = 4'hF;
  endtask

  task automatic model_step();
    int idx = int'(b_addr >> 2);
    bit inmap = (b_addr[1:0] == 2'b00) && idx < 10;
    bit en = m_ctrl[0];
    bit iss = m_pend && !e_busy;
    bit trig = 0;
    bit txne = txq.size() != 0;
    bit txfull = txq.size() == DEPTH;
    bit rxfull = rxq.size() == DEPTH;
    bit ovf = 0;
    logic [31:0] rv = 0;
    if (b_valid && !b_write && inmap) begin
      case (idx)
        0: rv = m_ctrl;
        1: rv = mstat();
        2: rv = m_mask;
        4: rv = !en ? 32'h0 : (rxq.size() == 0 ? 32'hDEADBEEF : rxq[0]);
        5: rv = m_cfg;
        6: rv = m_dma;
        7: rv = m_per;
        8: rv = m_test;
        default: rv = 0;
      endcase
    end
    m_ack = b_valid;
    m_rdata = (b_valid && !b_write) ? rv : 32'h0;
    if (b_valid && b_write && inmap && idx == 0 && !b_wdata[0]) begin
      model_reset();
      return;
    end
    if (b_valid && !b_write && inmap && idx == 4 && en && rxq.size() != 0)
      void'(rxq.pop_front());
    if (e_rxv) begin
      if (rxfull) ovf = 1; else rxq.push_back(e_rxw);
    end
    if (e_pop && txne) void'(txq.pop_front());
    if (b_valid && b_write && inmap && idx == 3 && en && !txfull) begin
      txq.push_back(b_wdata);
      if (m_ctrl[3] && mmaster(m_ctrl)) trig = 1;
    end
    if (b_valid && b_write && inmap && idx == 1) begin
      m_ro = (m_ro && !b_wdata[6]) || ovf;
      m_tc = (m_tc && !b_wdata[7]) || e_done;
    end else begin
      m_ro = m_ro || ovf;
      m_tc = m_tc || e_done;
    end
    if (b_valid && b_write && inmap) begin
      case (idx)
        0: begin
          if (mmaster(b_wdata)) begin
            m_cs = 4'hF & ~(4'h1 << ((b_wdata >> 12) & 3));
            if ((b_wdata[3] && !m_ctrl[3] && txne) ||
                (b_wdata[2] && !m_ctrl[2] && !b_wdata[3])) trig = 1;
          end
          m_ctrl = b_wdata;
        end
        2: m_mask = b_wdata;
        5: m_cfg = b_wdata;
        6: m_dma = b_wdata;
        7: m_per = b_wdata;
        8: m_test = b_wdata;
        default: ;
      endcase
    end
    m_pend = (m_pend && !iss) || trig;
  endtask

  task automatic compare();
    chk("R1 ack", {31'b0, ack}, {31'b0, m_ack});
    if (m_ack) chk(m_rtag, rdata, m_rdata);
    chk("R7 irq", {31'b0, irq}, {31'b0, |(mstat() & m_mask)});
    chk("R8 cs", {28'b0, cs}, {28'b0, m_cs});
    chk("R9 R10 start", {31'b0, start}, {31'b0, m_pend && !e_busy});
    chk("R4 avail", {31'b0, avail}, {31'b0, txq.size() != 0});
    if (txq.size() != 0) chk("R4 head", word, txq[0]);
  endtask

  task automatic tick();
    if (!rst_n) model_reset(); else model_step();
    @(negedge clk);
    compare();
    b_valid = 0; b_write = 0; e_pop = 0; e_rxv = 0; e_done = 0; m_rtag = "R1";
  endtask

  task automatic rawwr(logic [AW-1:0] a, logic [31:0] d);
    b_valid = 1; b_write = 1; b_addr = a; b_wdata = d; tick();
  endtask
  task automatic rawrd(logic [AW-1:0] a, string tag);
    b_valid = 1; b_write = 0; b_addr = a; m_rtag = tag; tick();
  endtask
  task automatic wr(int i, logic [31:0] d); rawwr(AW'(i * 4), d); endtask
  task automatic rd(int i, string tag); rawrd(AW'(i * 4), tag); endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    rd(1, "R6 status after reset");
    rd(4, "R2 disabled read");
    wr(3, 32'h1111_0000);                    // dropped while disabled, R4
    wr(0, EN | MODE0);                        // R8 ch0 master
    rd(4, "R2 empty read");
    // R11 storage
    wr(5, 32'hA5A5_0001); wr(6, 32'h0000_FF00); wr(7, 32'h1234_5678); wr(8, 32'hCAFE_F00D);
    wr(2, 32'h0000_0000);
    rd(5, "R11 cfg"); rd(6, "R11 dma"); rd(7, "R11 period"); rd(8, "R11 test");
    rd(0, "R11 ctrl"); rd(2, "R11 mask");
    // R1 out of map / unaligned
    wr(12, 32'hFFFF_FFFF); rd(12, "R1 past map");
    rawrd(AW'(5 * 4 + 1), "R1 unaligned read");
    rawwr(AW'(2 * 4 + 2), 32'hFFFF_FFFF); rd(2, "R1 unaligned write ignored");
    // R3
    wr(4, 32'h5555_5555); wr(9, 32'h7777_7777);
    rd(3, "R3 tx slot"); rd(9, "R3 msg slot"); rd(4, "R3 rx write ignored");
    // R4 push / engine pop
    for (int i = 0; i < 3; i++) wr(3, 32'h100 + i);
    e_pop = 1; tick();
    for (int i = 0; i < DEPTH; i++) wr(3, 32'h2000 + i);   // fills, last ones dropped
    rd(1, "R5 tx full status");
    wr(3, 32'hBAD0_0000);                                   // dropped, full
    for (int i = 0; i < DEPTH; i++) begin e_pop = 1; tick(); end
    // R2 pop order
    for (int i = 0; i < 3; i++) begin e_rxv = 1; e_rxw = 32'h300 + i; tick(); end
    for (int i = 0; i < 4; i++) rd(4, "R2 pop order");
    // R5 overrun, done, W1C; R7 irq
    for (int i = 0; i < DEPTH + 1; i++) begin e_rxv = 1; e_rxw = 32'h4000 + i; tick(); end
    rd(1, "R5 overrun set");
    wr(2, 32'h40); tick();                                  // R7 irq via overrun
    e_done = 1; tick();
    wr(2, 32'h80); rd(1, "R5 done set");
    e_done = 1; wr(1, 32'hFFFF_FFFF); rd(1, "R5 set wins");
    wr(1, 32'hFFFF_FFFF); rd(1, "R5 w1c only");
    wr(2, 32'h08); tick();                                  // R7 rx-ready irq
    for (int i = 0; i < DEPTH; i++) rd(4, "R2 drain");
    // R9 R10 starts
    wr(0, EN | MODE0 | KICK); tick(); tick();
    e_busy = 1;
    wr(0, EN | MODE0); wr(0, EN | MODE0 | KICK);
    repeat (4) tick();
    e_busy = 0; #1;
    chk("R10 released start", {31'b0, start}, 32'h1);
    tick(); tick();
    wr(0, EN | MODE0 | AUTO);                               // tx empty: no start
    wr(0, EN | MODE0 | AUTO | KICK);                        // kick with auto: no start
    tick();
    wr(3, 32'hAB); tick(); tick();                          // push with auto: start
    wr(0, EN | MODE0); wr(0, EN | MODE0 | AUTO); tick();    // auto rise with data
    e_pop = 1; tick();
    // non-master channel
    wr(0, EN | MODE0 | 32'h1000);
    wr(0, EN | MODE0 | 32'h1000 | KICK); tick();
    wr(0, EN | 32'h20 | 32'h1000);                          // ch1 master, R8
    wr(3, 32'h55); wr(8, 32'h1);
    // R6 soft reset
    wr(0, 32'h0000_0020);
    rd(1, "R6 status"); rd(0, "R6 ctrl"); rd(8, "R6 test"); rd(2, "R6 mask");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      vectors++; errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule